// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Victim Buffer

This block is a small read-only cache built from a direct-mapped line array and a few fully associative victim entries. A requester presents a word address. The block answers with the word and a flag that says whether it was found on chip. The low address bits pick the word within a line. The next bits pick the main-array slot. The remaining bits are kept as the tag. The main array and the victim entries are searched in the same cycle, so a hit in either one answers in the cycle after the request is taken.

When the line is found only among the victim entries, it is exchanged with the line in its main-array slot. No memory traffic is needed, and two lines that fight over one slot can both stay on chip. When neither structure holds the line, the block issues a line request over a valid/ready handshake. It then waits for the whole line to come back, writes it into the slot, and moves the slot's previous occupant into the victim entries. A busy output keeps further requests out while a refill is in flight.

Top module: `vcache_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, busy, resp_valid and mem_req_valid are low, and every line in both structures is marked invalid.
- R2: The word address is split as follows: bits [1:0] select the word within a line, bits [5:2] select the main-array slot, and bits [11:6] are the tag. The victim entries match on bits [11:2] as a whole. Only the tag is compared; the offset only picks the returned word.
- R3: A request taken (req_valid high while busy is low) that hits the main array gives resp_valid high one cycle later, with resp_hit high and the addressed word. No memory request is made.
- R4: A request that misses both structures raises busy and mem_req_valid in the next cycle. mem_req_addr carries address bits [11:2], and mem_req_valid and mem_req_addr hold until mem_req_ready. In the cycle after mem_rsp_valid, the block returns resp_valid with resp_hit low and the addressed word (word i of the line sits at bits [32*i+31:32*i]), and busy is low again.
- R5: A refill moves the valid line it displaces from the main array into the victim entries.
- R6: A request that hits only a victim entry answers with the same one-cycle latency and resp_hit high, with no memory request. The found line then takes the main-array slot, and the displaced line takes the freed victim entry.
- R7: A displaced line goes into the lowest-numbered empty victim entry. When all entries are full, entries are overwritten in rotation starting from entry 0.
- R8: An invalid line never matches. Every request right after reset misses, including address 0.
- R9: A request presented while busy is high is ignored. It produces no response and no memory request.
- R10: At most one victim entry matches a lookup, and a line is never present in both the main array and a victim entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 12 | Word address of the request |
| busy | output | 1 | Refill in progress; requests are ignored |
| resp_valid | output | 1 | Response present for one cycle |
| resp_hit | output | 1 | Response was served on chip |
| resp_data | output | 32 | Requested word |
| mem_req_valid | output | 1 | Line fetch request |
| mem_req_ready | input | 1 | Memory accepts the line fetch |
| mem_req_addr | output | 10 | Line address to fetch |
| mem_rsp_valid | input | 1 | Fetched line present |
| mem_rsp_data | input | 128 | Fetched line, word 0 in the low bits |

## Verification
Cold reads that start at address 0 and then walk all four offsets of one line show that a stale tag is never matched and that the word is taken from the right place. Two lines that alternate in one slot show whether a conflicting line comes back from the victim entries without a fetch, and whether each exchange keeps the other line. Six lines that map to one slot fill the victim entries and overflow them. A fixed order of re-reads then sorts out which entries were overwritten, so that a rotation fault appears as a hit that should have been a miss. A request held on the input during a slow refill shows whether anything leaks past busy.

// File: rtl/vcache_pkg.sv
package vcache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT
  } vc_state_t;
endpackage

// File: rtl/vcache_direct.sv
// Direct-mapped line storage: valid bits with reset, tag and data arrays without.
module vcache_direct #(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 6,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [LINE_W-1:0] data_mem [SETS];

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      data_mem[wr_idx] <= wr_line;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
  assign rd_line  = data_mem[rd_idx];
endmodule

// File: rtl/vcache_victim.sv
// Fully associative victim entries with parallel compare and rotating overwrite.
module vcache_victim #(
  parameter int ENTRIES = 4,
  parameter int LA_W    = 10,
  parameter int LINE_W  = 128,
  parameter int PTR_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LA_W-1:0]   look_la,
  output logic [ENTRIES-1:0] match,
  output logic              hit,
  output logic [PTR_W-1:0]  hit_idx,
  output logic [LINE_W-1:0] hit_line,
  output logic [PTR_W-1:0]  alloc_idx,
  input  logic              wr_en,
  input  logic              wr_alloc,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [LA_W-1:0]   wr_la,
  input  logic [LINE_W-1:0] wr_line
);
  logic [ENTRIES-1:0] valid_q;
  logic [LA_W-1:0]    la_mem   [ENTRIES];
  logic [LINE_W-1:0]  line_mem [ENTRIES];
  logic [PTR_W-1:0]   ptr_q;
  logic               full;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (la_mem[g] == look_la);
  end

  assign hit  = |match;
  assign full = &valid_q;

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) hit_idx = PTR_W'(i);
  end

  assign hit_line = line_mem[hit_idx];

  always_comb begin
    alloc_idx = ptr_q;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid_q[i]) alloc_idx = PTR_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= wr_valid;
      if (wr_alloc && full)
        ptr_q <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      la_mem[wr_idx]   <= wr_la;
      line_mem[wr_idx] <= wr_line;
    end
  end
endmodule

// File: rtl/vcache_top.sv
module vcache_top #(
  parameter int WORD_W         = 32,
  parameter int WORDS_PER_LINE = 4,
  parameter int NUM_SETS       = 16,
  parameter int VICTIM_ENTRIES = 4,
  parameter int ADDR_W         = 12,
  parameter int OFF_W          = $clog2(WORDS_PER_LINE),
  parameter int LA_W           = ADDR_W - OFF_W,
  parameter int LINE_W         = WORD_W * WORDS_PER_LINE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [WORD_W-1:0] resp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [LA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_data
);
  import vcache_pkg::*;

  localparam int IDX_W  = $clog2(NUM_SETS);
  localparam int TAG_W  = LA_W - IDX_W;
  localparam int VPTR_W = (VICTIM_ENTRIES > 1) ? $clog2(VICTIM_ENTRIES) : 1;

  vc_state_t         state_q;
  logic [LA_W-1:0]   miss_la_q;
  logic [OFF_W-1:0]  miss_off_q;
  logic              busy_q, resp_valid_q, resp_hit_q;
  logic [WORD_W-1:0] resp_data_q;

  logic              accept;
  logic [LA_W-1:0]   look_la;
  logic [IDX_W-1:0]  look_idx;
  logic [TAG_W-1:0]  look_tag;
  logic              rd_valid;
  logic [TAG_W-1:0]  rd_tag;
  logic [LINE_W-1:0] rd_line;
  logic              main_hit;
  logic [VICTIM_ENTRIES-1:0] vic_match;
  logic              vic_hit;
  logic [VPTR_W-1:0] vic_hit_idx, vic_alloc_idx;
  logic [LINE_W-1:0] vic_line;
  logic              do_swap, do_fill;

  function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_W-1:0] line,
                                                  input logic [OFF_W-1:0] off);
    return line[32'(off) * WORD_W +: WORD_W];
  endfunction

  assign accept   = req_valid && (state_q == ST_IDLE);
  assign look_la  = (state_q == ST_IDLE) ? req_addr[ADDR_W-1:OFF_W] : miss_la_q;
  assign look_idx = look_la[IDX_W-1:0];
  assign look_tag = look_la[LA_W-1:IDX_W];
  assign main_hit = rd_valid && (rd_tag == look_tag);
  assign do_swap  = accept && !main_hit && vic_hit;
  assign do_fill  = (state_q == ST_WAIT) && mem_rsp_valid;

  vcache_direct #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_main (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (look_idx),
    .rd_valid (rd_valid),
    .rd_tag   (rd_tag),
    .rd_line  (rd_line),
    .wr_en    (do_swap || do_fill),
    .wr_idx   (look_idx),
    .wr_tag   (look_tag),
    .wr_line  (do_swap ? vic_line : mem_rsp_data)
  );

  vcache_victim #(.ENTRIES(VICTIM_ENTRIES), .LA_W(LA_W), .LINE_W(LINE_W),
                  .PTR_W(VPTR_W)) u_victim (
    .clk       (clk),
    .rst       (rst),
    .look_la   (look_la),
    .match     (vic_match),
    .hit       (vic_hit),
    .hit_idx   (vic_hit_idx),
    .hit_line  (vic_line),
    .alloc_idx (vic_alloc_idx),
    .wr_en     (do_swap || (do_fill && rd_valid)),
    .wr_alloc  (do_fill),
    .wr_idx    (do_swap ? vic_hit_idx : vic_alloc_idx),
    .wr_valid  (rd_valid),
    .wr_la     ({rd_tag, look_idx}),
    .wr_line   (rd_line)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      busy_q       <= 1'b0;
      resp_valid_q <= 1'b0;
      resp_hit_q   <= 1'b0;
      resp_data_q  <= '0;
      miss_la_q    <= '0;
      miss_off_q   <= '0;
    end else begin
      resp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (main_hit || vic_hit) begin
            resp_valid_q <= 1'b1;
            resp_hit_q   <= 1'b1;
            resp_data_q  <= pick_word(main_hit ? rd_line : vic_line,
                                      req_addr[OFF_W-1:0]);
          end else begin
            state_q    <= ST_REQ;
            busy_q     <= 1'b1;
            miss_la_q  <= look_la;
            miss_off_q <= req_addr[OFF_W-1:0];
          end
        end
        ST_REQ: if (mem_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          state_q      <= ST_IDLE;
          busy_q       <= 1'b0;
          resp_valid_q <= 1'b1;
          resp_hit_q   <= 1'b0;
          resp_data_q  <= pick_word(mem_rsp_data, miss_off_q);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy          = busy_q;
  assign resp_valid    = resp_valid_q;
  assign resp_hit      = resp_hit_q;
  assign resp_data     = resp_data_q;
  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_req_addr  = miss_la_q;
endmodule

// File: rtl/vcache_checker.sv
module vcache_checker #(
  parameter int VE   = 4,
  parameter int LA_W = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            resp_valid,
  input logic            resp_hit,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [LA_W-1:0] mem_req_addr,
  input logic            mem_rsp_valid,
  input logic            accept,
  input logic            main_hit,
  input logic            vic_hit,
  input logic [VE-1:0]   vic_match
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!busy && !resp_valid && !mem_req_valid));

  a_r3_hit_latency: assert property (@(posedge clk) disable iff (rst)
    (accept && (main_hit || vic_hit)) |=> (resp_valid && resp_hit && !mem_req_valid));

  a_r4_miss_fetch: assert property (@(posedge clk) disable iff (rst)
    (accept && !main_hit && !vic_hit) |=> (busy && mem_req_valid));

  a_r4_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r4_miss_resp_src: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_hit) |-> $past(mem_rsp_valid));

  a_r9_busy_silent: assert property (@(posedge clk) disable iff (rst)
    (busy && !mem_rsp_valid) |=> !resp_valid);

  a_r10_one_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(vic_match));

  a_r10_no_dup: assert property (@(posedge clk) disable iff (rst)
    !(main_hit && vic_hit));
endmodule

bind vcache_top vcache_checker #(.VE(VICTIM_ENTRIES), .LA_W(LA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .busy          (busy),
  .resp_valid    (resp_valid),
  .resp_hit      (resp_hit),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .accept        (accept),
  .main_hit      (main_hit),
  .vic_hit       (vic_hit),
  .vic_match     (vic_match)
);

// File: tb/sim_vcache_top.sv
module sim_vcache_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic [11:0]  req_addr = '0;
  logic         busy, resp_valid, resp_hit;
  logic [31:0]  resp_data;
  logic         mem_req_valid;
  logic         mem_req_ready = 1'b0;
  logic [9:0]   mem_req_addr;
  logic         mem_rsp_valid = 1'b0;
  logic [127:0] mem_rsp_data = '0;

  int n_checks = 0;
  int n_fail   = 0;
  int fetches  = 0;
  int ready_dly = 1;
  int rsp_dly   = 2;
  bit finished  = 0;

  always #5 clk = ~clk;

  vcache_top u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .busy(busy), .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_data(resp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [31:0] word_of(input logic [9:0] la, input int i);
    return 32'hC0DE0000 | (32'(la) << 4) | 32'(i);
  endfunction

  function automatic logic [127:0] line_of(input logic [9:0] la);
    logic [127:0] l;
    for (int i = 0; i < 4; i++) l[32*i +: 32] = word_of(la, i);
    return l;
  endfunction

  function automatic logic [11:0] mk(input int tag, input int idx, input int off);
    return {6'(tag), 4'(idx), 2'(off)};
  endfunction

  // memory model: answers each line request with a fixed pattern
  initial begin
    logic [9:0] la;
    forever begin
      @(negedge clk);
      if (mem_req_valid && !rst) begin
        la = mem_req_addr;
        fetches++;
        repeat (ready_dly) @(negedge clk);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (rsp_dly) @(negedge clk);
        mem_rsp_data  = line_of(la);
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] a, output logic hit,
                         output logic [31:0] d, output int lat);
    while (busy) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!resp_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    hit = resp_hit;
    d   = resp_data;
  endtask

  // read and check hit flag, data, latency for hits, and fetch count
  task automatic rd_expect(input logic [11:0] a, input bit exp_hit, input string req);
    logic h; logic [31:0] d; int lat; int f0;
    f0 = fetches;
    do_read(a, h, d, lat);
    chk(h == exp_hit, req, "hit flag", longint'(h), longint'(exp_hit));
    chk(d == word_of(a[11:2], int'(a[1:0])), req, "data", longint'(d),
        longint'(word_of(a[11:2], int'(a[1:0]))));
    if (exp_hit) begin
      chk(lat == 1, req, "hit latency", lat, 1);
      chk(fetches == f0, req, "no fetch on hit", fetches, f0);
    end else begin
      chk(fetches == f0 + 1, req, "one fetch on miss", fetches, f0 + 1);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk(!busy, "R1", "busy after reset", busy, 0);
    chk(!resp_valid, "R1", "resp_valid after reset", resp_valid, 0);
    chk(!mem_req_valid, "R1", "mem_req_valid after reset", mem_req_valid, 0);
  endtask

  task automatic t_cold();
    do_reset();
    rd_expect(mk(0, 0, 0), 1'b0, "R8");   // tag 0 at slot 0 must not match after reset
    rd_expect(mk(0, 0, 3), 1'b1, "R3");
    rd_expect(mk(7, 12, 1), 1'b0, "R4");
  endtask

  task automatic t_offsets();
    do_reset();
    rd_expect(mk(5, 9, 2), 1'b0, "R2");
    for (int o = 0; o < 4; o++) rd_expect(mk(5, 9, o), 1'b1, "R2");
  endtask

  task automatic t_conflict();
    do_reset();
    rd_expect(mk(1, 3, 2), 1'b0, "R4");
    rd_expect(mk(2, 3, 1), 1'b0, "R5");
    rd_expect(mk(1, 3, 0), 1'b1, "R6");   // evicted line found in victim entry
    rd_expect(mk(2, 3, 3), 1'b1, "R6");   // displaced line kept by the swap
    rd_expect(mk(1, 3, 1), 1'b1, "R6");
  endtask

  task automatic t_rotation();
    do_reset();
    for (int t = 1; t <= 6; t++) rd_expect(mk(t, 5, 0), 1'b0, "R7");
    // entries now: e0=t5 e1=t2 e2=t3 e3=t4, next overwrite e1
    rd_expect(mk(1, 5, 1), 1'b0, "R7");   // t1 was overwritten first
    rd_expect(mk(2, 5, 2), 1'b0, "R7");   // t6 pushed into e1 over t2
    rd_expect(mk(4, 5, 3), 1'b1, "R7");   // t4 still in e3
    rd_expect(mk(5, 5, 0), 1'b1, "R7");   // t5 still in e0
    rd_expect(mk(3, 5, 0), 1'b0, "R7");   // t1 pushed into e2 over t3
  endtask

  task automatic t_busy();
    int f0; int nresp; logic [31:0] d;
    do_reset();
    ready_dly = 5;
    f0 = fetches;
    nresp = 0;
    d = '0;
    req_valid = 1'b1;
    req_addr  = mk(3, 1, 2);
    @(negedge clk);
    req_addr  = mk(4, 2, 0);              // stays presented while busy
    chk(busy, "R9", "busy during refill", busy, 1);
    for (int c = 0; c < 30; c++) begin
      if (resp_valid) begin
        nresp++;
        d = resp_data;
      end
      if (!busy && resp_valid) req_valid = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    ready_dly = 1;
    chk(nresp == 1, "R9", "responses during hold", nresp, 1);
    chk(d == word_of(mk(3, 1, 2) >> 2, 2), "R9", "data of taken request", d,
        word_of(mk(3, 1, 2) >> 2, 2));
    chk(fetches == f0 + 1, "R9", "fetches during hold", fetches, f0 + 1);
    rd_expect(mk(4, 2, 0), 1'b0, "R9");   // held request never fetched
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_cold();
    t_offsets();
    t_conflict();
    t_rotation();
    t_busy();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule